// File: doc/BRIEF.md
# I2C Software Interaction Priority Arbiter

This block sits beside an I2C master/slave engine and settles what happens each time that engine stops at a decision point that software must resolve. The engine presents a request together with a mask of the interactions its present state accepts. The arbiter checks which of those interactions already have their condition met. Conditions come from latched early commands, the auto-acknowledge enable, the transmit-buffer head (presence, whether it is an address, its read/write bit) and receive-buffer space. The arbiter grants the most urgent interaction with a met condition. If none is met, it keeps SCL low and raises a sticky bus-hold interrupt until one is met.

The request side works as a simple request/response handshake. The engine raises `need_valid` with `need_mask` and keeps both stable until it sees `sel_valid`. It drops `need_valid` on the clock edge that follows the strobe cycle, so it accepts the grant at once and has no back-pressure on it. During the strobe cycle the arbiter ignores `need_valid`, so one request yields exactly one grant. Command inputs are single-cycle pulses from the register front end. Buffer status lines are plain levels.

Top module: `i2c_ia_arbiter`

## Requirements
- R1: After reset, `sel_valid`, `sel_onehot`, `scl_hold` and `irq_hold` are all zero, and no command is pending.
- R2: Interaction bit positions in `need_mask` and `sel_onehot` also give the priority order, highest first: bit0 stop, bit1 abort, bit2 continue, bit3 nack, bit4 ack, bit5 address with read bit set, bit6 address with read bit clear, bit7 start, bit8 transmit data, bit9 receive data, bit10 no interaction. The grant is the lowest-numbered bit that is both allowed by the mask and satisfied.
- R3: `sel_valid` pulses high for exactly one cycle, with `sel_onehot` holding one set bit, on the clock edge after the first cycle in which a request has a satisfied, allowed interaction.
- R4: If a request has no satisfied, allowed interaction, `scl_hold` goes high one edge later and stays high. It drops on the same edge that raises `sel_valid`.
- R5: `irq_hold` is set on every rising edge of `scl_hold` and stays set until `irq_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R6: A stop, continue, nack, ack or start command issued before it is needed is held pending. The pending command later satisfies its interaction. The pending bit is cleared on the edge where that interaction is granted.
- R7: The ack interaction is satisfied whenever `auto_ack` is high, with no command.
- R8: Abort is satisfied only by `cmd_abort` pulsed while a request that allows abort is waiting. An abort pulse outside that is discarded.
- R9: Address interactions need `tx_valid` with `tx_is_addr` high, and bit5 or bit6 is chosen by `tx_rw` (1 or 0). A data head (`tx_is_addr` low) satisfies only transmit data. In the master-transmitter wait for an address, the bus stays held until an address entry appears.
- R10: Receive data is satisfied by `rx_space`.
- R11: No interaction (bit10) is granted only when the mask allows it. A request whose mask allows nothing satisfied holds the bus.
- R12: A pending command whose interaction is not granted remains pending for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| need_valid | input | 1 | Engine waits at a decision point |
| need_mask | input | 11 | Interactions allowed in the present state |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_abort | input | 1 | Abort command pulse |
| cmd_cont | input | 1 | Continue command pulse |
| cmd_nack | input | 1 | Nack command pulse |
| cmd_ack | input | 1 | Ack command pulse |
| cmd_start | input | 1 | Start command pulse |
| auto_ack | input | 1 | Acknowledge automatically |
| tx_valid | input | 1 | Transmit buffer holds an entry |
| tx_is_addr | input | 1 | Head entry is an address |
| tx_rw | input | 1 | Read/write bit of the head address |
| rx_space | input | 1 | Receive buffer has room |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| sel_valid | output | 1 | One-cycle grant strobe |
| sel_onehot | output | 11 | Granted interaction |
| scl_hold | output | 1 | Keep SCL low |
| irq_hold | output | 1 | Sticky bus-hold interrupt |

## Verification
A corrupted pending bit becomes visible at the next request that allows its interaction. A lost bit shows as an unexpected hold, and a stale bit shows as a grant of that interaction without a command. Either appears one edge after the request is raised. A wrong priority link or condition term shows up on the first grant in which two satisfied interactions compete. The hold and interrupt registers give themselves away one edge after a request with nothing satisfied: the hold stays low or the interrupt is missing. A lost interrupt set in the same cycle as a clear shows on that same edge.

// File: rtl/i2c_ia_pkg.sv
package i2c_ia_pkg;
  localparam int IA_N       = 11;
  localparam int IA_STOP    = 0;
  localparam int IA_ABORT   = 1;
  localparam int IA_CONT    = 2;
  localparam int IA_NACK    = 3;
  localparam int IA_ACK     = 4;
  localparam int IA_ADDR_RD = 5;
  localparam int IA_ADDR_WR = 6;
  localparam int IA_START   = 7;
  localparam int IA_TXDATA  = 8;
  localparam int IA_RXDATA  = 9;
  localparam int IA_NONE    = 10;

  // commands that may be issued early and held
  localparam int PEND_N     = 5;
  localparam int P_STOP     = 0;
  localparam int P_CONT     = 1;
  localparam int P_NACK     = 2;
  localparam int P_ACK      = 3;
  localparam int P_START    = 4;

  typedef logic [IA_N-1:0]   ia_vec_t;
  typedef logic [PEND_N-1:0] pend_vec_t;

  function automatic int pend_to_ia(input int p);
    case (p)
      P_STOP:  return IA_STOP;
      P_CONT:  return IA_CONT;
      P_NACK:  return IA_NACK;
      P_ACK:   return IA_ACK;
      default: return IA_START;
    endcase
  endfunction
endpackage

// File: rtl/ia_pend.sv
module ia_pend #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cmd,
  input  logic [N-1:0] consume,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= (pend[i] | cmd[i]) & ~consume[i];
    end
  end
endmodule

// File: rtl/ia_cond.sv
module ia_cond
  import i2c_ia_pkg::*;
(
  input  pend_vec_t pend,
  input  pend_vec_t cmd,
  input  logic      cmd_abort,
  input  logic      auto_ack,
  input  logic      tx_valid,
  input  logic      tx_is_addr,
  input  logic      tx_rw,
  input  logic      rx_space,
  output ia_vec_t   cond
);
  pend_vec_t have;
  assign have = pend | cmd;

  always_comb begin
    cond             = '0;
    cond[IA_STOP]    = have[P_STOP];
    cond[IA_ABORT]   = cmd_abort;
    cond[IA_CONT]    = have[P_CONT];
    cond[IA_NACK]    = have[P_NACK];
    cond[IA_ACK]     = have[P_ACK] | auto_ack;
    cond[IA_ADDR_RD] = tx_valid & tx_is_addr & tx_rw;
    cond[IA_ADDR_WR] = tx_valid & tx_is_addr & ~tx_rw;
    cond[IA_START]   = have[P_START];
    cond[IA_TXDATA]  = tx_valid & ~tx_is_addr;
    cond[IA_RXDATA]  = rx_space;
    cond[IA_NONE]    = 1'b1;
  end
endmodule

// File: rtl/ia_pick.sv
module ia_pick #(
  parameter int N = 11
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] above;
  assign above[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = req[i] & ~above[i];
    assign above[i+1] = above[i] | req[i];
  end
  assign any = above[N];
endmodule

// File: rtl/ia_hold.sv
module ia_hold #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         need,
  input  logic         any,
  input  logic [N-1:0] grant,
  input  logic         irq_clr,
  output logic         take,
  output logic         sel_valid,
  output logic [N-1:0] sel_onehot,
  output logic         scl_hold,
  output logic         irq_hold
);
  logic live;
  logic hold_nxt;

  assign live     = need & ~sel_valid;
  assign take     = live & any;
  assign hold_nxt = live & ~any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_onehot <= '0;
      scl_hold   <= 1'b0;
      irq_hold   <= 1'b0;
    end else begin
      sel_valid  <= take;
      sel_onehot <= take ? grant : '0;
      scl_hold   <= hold_nxt;
      if (hold_nxt && !scl_hold) irq_hold <= 1'b1;
      else if (irq_clr)          irq_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_ia_arbiter.sv
module i2c_ia_arbiter
  import i2c_ia_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            need_valid,
  input  logic [IA_N-1:0] need_mask,
  input  logic            cmd_stop,
  input  logic            cmd_abort,
  input  logic            cmd_cont,
  input  logic            cmd_nack,
  input  logic            cmd_ack,
  input  logic            cmd_start,
  input  logic            auto_ack,
  input  logic            tx_valid,
  input  logic            tx_is_addr,
  input  logic            tx_rw,
  input  logic            rx_space,
  input  logic            irq_clr,
  output logic            sel_valid,
  output logic [IA_N-1:0] sel_onehot,
  output logic            scl_hold,
  output logic            irq_hold
);
  pend_vec_t cmd_vec, pend, consume;
  ia_vec_t   cond, grant;
  logic      any, take;

  always_comb begin
    cmd_vec          = '0;
    cmd_vec[P_STOP]  = cmd_stop;
    cmd_vec[P_CONT]  = cmd_cont;
    cmd_vec[P_NACK]  = cmd_nack;
    cmd_vec[P_ACK]   = cmd_ack;
    cmd_vec[P_START] = cmd_start;
  end

  for (genvar p = 0; p < PEND_N; p++) begin : g_consume
    assign consume[p] = take & grant[pend_to_ia(p)];
  end

  ia_pend #(.N(PEND_N)) u_pend (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_vec), .consume(consume), .pend(pend)
  );

  ia_cond u_cond (
    .pend(pend), .cmd(cmd_vec), .cmd_abort(cmd_abort), .auto_ack(auto_ack),
    .tx_valid(tx_valid), .tx_is_addr(tx_is_addr), .tx_rw(tx_rw),
    .rx_space(rx_space), .cond(cond)
  );

  ia_pick #(.N(IA_N)) u_pick (
    .req(cond & need_mask), .grant(grant), .any(any)
  );

  ia_hold #(.N(IA_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .need(need_valid), .any(any), .grant(grant),
    .irq_clr(irq_clr), .take(take), .sel_valid(sel_valid),
    .sel_onehot(sel_onehot), .scl_hold(scl_hold), .irq_hold(irq_hold)
  );
endmodule

// File: rtl/ia_arb_chk.sv
module ia_arb_chk
  import i2c_ia_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [IA_N-1:0] need_mask,
  input logic            cmd_abort,
  input logic            irq_clr,
  input logic            sel_valid,
  input logic [IA_N-1:0] sel_onehot,
  input logic            scl_hold,
  input logic            irq_hold
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $countones(sel_onehot) == 1);
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !sel_valid);
  p_hold_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_valid && scl_hold));
  p_hold_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> irq_hold);
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hold && !irq_clr |=> irq_hold);
  p_in_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_onehot & $past(need_mask)) != '0);
  p_abort_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_onehot[IA_ABORT] |-> $past(cmd_abort));
endmodule

bind i2c_ia_arbiter ia_arb_chk u_chk (.*);

// File: tb/sim_i2c_ia_arbiter.sv
module sim_i2c_ia_arbiter;
  import i2c_ia_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic need_valid = 1'b0;
  logic [IA_N-1:0] need_mask = '0;
  logic cmd_stop = 0, cmd_abort = 0, cmd_cont = 0, cmd_nack = 0, cmd_ack = 0, cmd_start = 0;
  logic auto_ack = 0, tx_valid = 0, tx_is_addr = 0, tx_rw = 0, rx_space = 0, irq_clr = 0;
  logic sel_valid, scl_hold, irq_hold;
  logic [IA_N-1:0] sel_onehot;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  i2c_ia_arbiter u0 (.*);

  function automatic ia_vec_t b(input int i);
    ia_vec_t v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ask(input ia_vec_t m);
    need_mask = m;
    need_valid = 1'b1;
    step();
  endtask

  task automatic expect_sel(input ia_vec_t exp, input string tag);
    chk(sel_valid == 1'b1, {tag, " strobe"}, sel_valid, 1);
    chk(sel_onehot == exp, {tag, " grant"}, sel_onehot, exp);
    chk(scl_hold == 1'b0, {tag, " hold released"}, scl_hold, 0);
    need_valid = 1'b0;
    step();
    chk(sel_valid == 1'b0, {tag, " strobe width"}, sel_valid, 0);
  endtask

  task automatic expect_hold(input string tag);
    chk(sel_valid == 1'b0, {tag, " no grant"}, sel_valid, 0);
    chk(scl_hold == 1'b1, {tag, " hold"}, scl_hold, 1);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(sel_valid == 0 && scl_hold == 0 && irq_hold == 0 && sel_onehot == 0,
        "R1 reset outputs", {sel_valid, scl_hold, irq_hold}, 0);
    // R1: nothing pending: a stop/start-only request must hold
    ask(b(IA_STOP) | b(IA_START));
    expect_hold("R1 no pending after reset");
    tx_valid = 1'b1; tx_is_addr = 1'b1; tx_rw = 1'b0;
    need_mask = b(IA_ADDR_WR);
    step();
    expect_sel(b(IA_ADDR_WR), "R1 release");
    tx_valid = 1'b0; tx_is_addr = 1'b0;
    clear_irq();
  endtask

  task automatic t_priority();
    auto_ack = 1'b1; tx_valid = 1'b1; rx_space = 1'b1;
    ask('1);
    expect_sel(b(IA_ACK), "R2 ack over data");
    auto_ack = 1'b0; tx_valid = 1'b0;
    ask(b(IA_TXDATA) | b(IA_RXDATA) | b(IA_NONE));
    expect_sel(b(IA_RXDATA), "R10 rx over none");
    tx_valid = 1'b1;
    ask(b(IA_TXDATA) | b(IA_RXDATA) | b(IA_NONE));
    expect_sel(b(IA_TXDATA), "R2 tx over rx");
    tx_is_addr = 1'b1; tx_rw = 1'b1;
    ask(b(IA_ADDR_RD) | b(IA_ADDR_WR) | b(IA_TXDATA));
    expect_sel(b(IA_ADDR_RD), "R9 read address");
    tx_valid = 1'b0; tx_is_addr = 1'b0; tx_rw = 1'b0; rx_space = 1'b0;
  endtask

  task automatic t_hold_irq();
    ask(b(IA_TXDATA));
    expect_hold("R4 enter");
    chk(irq_hold == 1'b1, "R5 irq on hold", irq_hold, 1);
    repeat (3) step();
    expect_hold("R4 stays");
    tx_valid = 1'b1;
    step();
    expect_sel(b(IA_TXDATA), "R3 release edge");
    chk(irq_hold == 1'b1, "R5 sticky", irq_hold, 1);
    clear_irq();
    chk(irq_hold == 1'b0, "R5 cleared", irq_hold, 0);
    tx_valid = 1'b0;
    // set and clear together: set wins
    irq_clr = 1'b1;
    ask(b(IA_TXDATA));
    irq_clr = 1'b0;
    chk(irq_hold == 1'b1, "R5 set wins", irq_hold, 1);
    tx_valid = 1'b1;
    step();
    expect_sel(b(IA_TXDATA), "R5 resolve");
    tx_valid = 1'b0;
    clear_irq();
  endtask

  task automatic t_pending();
    cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
    chk(sel_valid == 1'b0, "R6 early cmd idle", sel_valid, 0);
    tx_valid = 1'b1;
    ask(b(IA_STOP) | b(IA_TXDATA));
    expect_sel(b(IA_STOP), "R6 pending stop");
    tx_valid = 1'b0;
    ask(b(IA_STOP) | b(IA_NONE));
    expect_sel(b(IA_NONE), "R6 pending consumed");
    // R12: cont pending survives an rx grant
    cmd_cont = 1'b1; step(); cmd_cont = 1'b0;
    rx_space = 1'b1;
    ask(b(IA_RXDATA));
    expect_sel(b(IA_RXDATA), "R12 other grant");
    rx_space = 1'b0;
    ask(b(IA_CONT) | b(IA_NONE));
    expect_sel(b(IA_CONT), "R12 still pending");
    // start issued while waiting
    ask(b(IA_START));
    expect_hold("R6 start wait");
    cmd_start = 1'b1; step(); cmd_start = 1'b0;
    expect_sel(b(IA_START), "R6 live start");
    clear_irq();
  endtask

  task automatic t_abort_ack();
    cmd_abort = 1'b1; step(); cmd_abort = 1'b0;
    ask(b(IA_ABORT) | b(IA_NONE));
    expect_sel(b(IA_NONE), "R8 early abort dropped");
    ask(b(IA_ABORT));
    expect_hold("R8 wait");
    cmd_abort = 1'b1; step(); cmd_abort = 1'b0;
    expect_sel(b(IA_ABORT), "R8 live abort");
    auto_ack = 1'b1;
    ask(b(IA_ACK) | b(IA_NACK));
    expect_sel(b(IA_ACK), "R7 auto ack");
    auto_ack = 1'b0;
    ask(b(IA_ACK));
    expect_hold("R7 manual wait");
    cmd_ack = 1'b1; step(); cmd_ack = 1'b0;
    expect_sel(b(IA_ACK), "R7 manual ack");
    cmd_nack = 1'b1; step(); cmd_nack = 1'b0;
    auto_ack = 1'b1;
    ask(b(IA_ACK) | b(IA_NACK));
    expect_sel(b(IA_NACK), "R2 nack over ack");
    auto_ack = 1'b0;
    clear_irq();
  endtask

  task automatic t_addr_wait();
    rx_space = 1'b1;
    ask(b(IA_ADDR_RD) | b(IA_ADDR_WR));
    expect_hold("R9 empty");
    chk(sel_valid == 1'b0, "R11 rx not allowed", sel_valid, 0);
    tx_valid = 1'b1; tx_is_addr = 1'b0;
    step();
    expect_hold("R9 data head");
    tx_is_addr = 1'b1; tx_rw = 1'b0;
    step();
    expect_sel(b(IA_ADDR_WR), "R9 write address");
    tx_valid = 1'b0; tx_is_addr = 1'b0; rx_space = 1'b0;
    ask(b(IA_TXDATA) | b(IA_RXDATA));
    expect_hold("R11 none not allowed");
    need_mask = b(IA_TXDATA) | b(IA_NONE);
    step();
    expect_sel(b(IA_NONE), "R11 none allowed");
    clear_irq();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_priority();
    t_hold_irq();
    t_pending();
    t_abort_ack();
    t_addr_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule